// File: doc/BRIEF.md
# Power-of-Two Scaled Watchdog Timer

This block is a watchdog timer that counts an external slow tick, nominally one pulse per millisecond. A three-bit scale field in a small register bank sets the timeout. Code zero turns the timer off. Each code from 1 to 7 doubles the timeout, starting from a base period. With the default base of 2048 ticks, the timeouts are about 2, 4, 8, 16, 32, 65 and 131 seconds. After reset the scale is 3, which is about 8 seconds.

Software keeps the system alive by writing a one to a ping bit in a second register. The ping bit clears itself and always reads as zero. If the count reaches the selected timeout, the block raises a reset request. That request stays high until the block itself is reset.

The register port is a plain single-cycle write strobe with a shared address. Read data is combinational from the same address.

Top module: `wdg_scaled_top`

## Requirements
- R1: After reset the scale field reads 3 at address 0 and `rst_req_o` is low.
- R2: While the scale is 0, the watchdog never expires, however many ticks arrive.
- R3: For scale code k in 1..7, `rst_req_o` rises on the clock edge that samples the (BASE_TICKS·2^(k-1))-th tick since the count last started.
- R4: Writing data bit 0 = 1 to address 1 while enabled and not expired clears the elapsed count. On that edge the ping takes priority over a coincident tick.
- R5: A ping written while the scale is 0 has no effect on the count.
- R6: Writing a nonzero scale while disabled starts the count from zero elapsed ticks.
- R7: Writing a scale value different from the current one restarts the count. Rewriting the same value leaves the count running.
- R8: Once raised, `rst_req_o` stays high through pings, scale writes and ticks until `rst_n` is asserted.
- R9: Clock cycles without `tick_i` do not advance the count.
- R10: Address 0 reads the scale in bits [2:0] with zeros above it, and a write there keeps only bits [2:0]. Address 1 and any other address read zero. Writes to addresses other than 0 and 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow time-base pulse, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for both read and write |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data for `addr_i` |
| rst_req_o | output | 1 | Sticky reset request on timeout |

## Verification
The bench targets the exact expiry edge for every scale code. It checks one tick before the edge and on the edge, so an off-by-one compare or a wrong shift would show up as a timeout at the wrong tick.

It also covers the awkward cases:
- A ping in the same cycle as a tick. A design that lets the tick win would expire one tick early.
- Rewriting the same scale versus a different one. A design that restarts on every write, or never restarts, moves the expiry edge.
- A ping while disabled.
- Writes that follow expiry. A design whose request is not sticky would drop `rst_req_o`.

// File: rtl/wdg_scaled_pkg.sv
package wdg_scaled_pkg;
    localparam int SEL_W   = 3;
    localparam int NUM_SEL = 1 << SEL_W;

    typedef logic [SEL_W-1:0] sel_t;

    localparam sel_t SEL_OFF   = sel_t'(0);
    localparam sel_t SEL_RESET = sel_t'(3);
endpackage

// File: rtl/wdg_scaled_regs.sv
module wdg_scaled_regs
    import wdg_scaled_pkg::*;
#(
    parameter int ADDR_W     = 2,
    parameter int DATA_W     = 8,
    parameter int ADDR_SCALE = 0,
    parameter int ADDR_KICK  = 1,
    parameter int PING_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output sel_t              sel_o,
    output logic              ping_o,
    output logic              sel_change_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam logic [ADDR_W-1:0] A_SCALE = ADDR_W'(ADDR_SCALE);
    localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(ADDR_KICK);

    typedef struct packed {
        sel_t sel;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  hit_scale, hit_kick;
    logic  unused_hi;

    assign hit_scale = wr_en && (addr == A_SCALE);
    assign hit_kick  = wr_en && (addr == A_KICK);
    assign unused_hi = ^wr_data;

    always_comb begin
        regs_d = regs_q;
        if (hit_scale) begin
            regs_d.sel = wr_data[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.sel <= SEL_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (addr == A_SCALE) begin
            rd_data_o[SEL_W-1:0] = regs_q.sel;
        end
    end

    assign sel_o        = regs_q.sel;
    assign ping_o       = hit_kick && wr_data[PING_BIT];
    assign sel_change_o = hit_scale && (wr_data[SEL_W-1:0] != regs_q.sel);

    // R10: without a write strobe the scale never moves
    assert_scale_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sel_o));
endmodule

// File: rtl/wdg_scaled_lut.sv
module wdg_scaled_lut
    import wdg_scaled_pkg::*;
#(
    parameter int BASE_TICKS = 2048,
    parameter int CNT_W      = 18
) (
    input  sel_t             sel,
    output logic [CNT_W-1:0] limit_o
);
    logic [CNT_W-1:0] tbl [NUM_SEL];

    for (genvar c = 0; c < NUM_SEL; c++) begin : g_row
        if (c == 0) begin : g_off
            assign tbl[c] = '0;
        end else begin : g_on
            assign tbl[c] = CNT_W'(BASE_TICKS) << (c - 1);
        end
    end

    assign limit_o = tbl[sel];
endmodule

// File: rtl/wdg_scaled_core.sv
module wdg_scaled_core
    import wdg_scaled_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  sel_t             sel,
    input  logic [CNT_W-1:0] limit,
    input  logic             ping,
    input  logic             sel_change,
    output logic             expired_o
);
    typedef struct packed {
        logic [CNT_W-1:0] elapsed;
        logic             expired;
    } core_t;

    core_t core_d, core_q;
    logic  enabled;
    logic  restart;

    assign enabled = (sel != SEL_OFF);
    assign restart = sel_change || (ping && enabled);

    always_comb begin
        core_d = core_q;
        if (!core_q.expired) begin
            if (!enabled || restart) begin
                core_d.elapsed = '0;
            end else if (tick) begin
                core_d.elapsed = core_q.elapsed + 1'b1;
                if ((core_q.elapsed + 1'b1) >= limit) begin
                    core_d.expired = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign expired_o = core_q.expired;

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.expired |=> core_q.expired);

    assert_idle_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_OFF && !core_q.expired) |=> (core_q.elapsed == '0 && !core_q.expired));

    assert_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && !core_q.expired) |-> (core_q.elapsed < limit));

    assert_ping_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ping && enabled && !core_q.expired) |=> (core_q.elapsed == '0 && !core_q.expired));

    assert_change_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_change && !core_q.expired) |=> (core_q.elapsed == '0));

    assert_tick_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !core_q.expired) |=> !core_q.expired);
endmodule

// File: rtl/wdg_scaled_top.sv
module wdg_scaled_top
    import wdg_scaled_pkg::*;
#(
    parameter int BASE_TICKS = 2048,
    parameter int ADDR_W     = 2,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rst_req_o
);
    localparam int MAX_LIMIT = BASE_TICKS * (1 << (NUM_SEL - 2));
    localparam int CNT_W     = $clog2(MAX_LIMIT) + 1;

    sel_t             sel;
    logic             ping;
    logic             sel_change;
    logic [CNT_W-1:0] limit;

    wdg_scaled_regs #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .ADDR_SCALE (0),
        .ADDR_KICK  (1),
        .PING_BIT   (0)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en_i),
        .addr         (addr_i),
        .wr_data      (wr_data_i),
        .sel_o        (sel),
        .ping_o       (ping),
        .sel_change_o (sel_change),
        .rd_data_o    (rd_data_o)
    );

    wdg_scaled_lut #(
        .BASE_TICKS (BASE_TICKS),
        .CNT_W      (CNT_W)
    ) u_lut (
        .sel     (sel),
        .limit_o (limit)
    );

    wdg_scaled_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_i),
        .sel        (sel),
        .limit      (limit),
        .ping       (ping),
        .sel_change (sel_change),
        .expired_o  (rst_req_o)
    );

    // R3: the request only rises on an edge that sampled a tick
    assert_rise_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> $past(tick_i));
endmodule

// File: tb/tb_wdg_scaled_top.sv
module tb_wdg_scaled_top;
    localparam int BASE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       rst_req;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles = 0;
    string phase = "R1";

    int m_sel = 3;
    int m_el  = 0;
    int m_exp = 0;

    wdg_scaled_top #(.BASE_TICKS(BASE), .ADDR_W(2), .DATA_W(8)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .wr_en_i   (wr),
        .addr_i    (addr),
        .wr_data_i (wdata),
        .rd_data_o (rdata),
        .rst_req_o (rst_req)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lim_of(input int s);
        return (s == 0) ? 0 : (BASE << (s - 1));
    endfunction

    // behavioural reference, updated per edge and compared shortly after
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 3; m_el = 0; m_exp = 0;
        end else begin
            int  lim;
            bit  chg, png;
            lim = lim_of(m_sel);
            chg = wr && addr == 2'd0 && int'(wdata[2:0]) != m_sel;
            png = wr && addr == 2'd1 && wdata[0] && m_sel != 0;
            if (m_exp == 0) begin
                if (m_sel == 0 || chg || png) m_el = 0;
                else if (tick) begin
                    m_el = m_el + 1;
                    if (m_el >= lim) m_exp = 1;
                end
            end
            if (wr && addr == 2'd0) m_sel = int'(wdata[2:0]);
        end
        #2;
        if (rst_n) begin
            chk({phase, " rst_req"}, int'(rst_req), m_exp);
            chk({phase, " rd_data"}, int'(rdata), (addr == 2'd0) ? m_sel : 0);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic step(input logic t, input logic w, input logic [1:0] a, input logic [7:0] d);
        tick = t; wr = w; addr = a; wdata = d;
        @(negedge clk);
        tick = 1'b0; wr = 1'b0; addr = 2'd0; wdata = 8'd0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 2'd0, 8'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(1'b0, 1'b0, 2'd0, 8'd0);
        step(1'b0, 1'b0, 2'd0, 8'd0);
        rst_n = 1'b1;
    endtask

    task automatic wr_scale(input logic [7:0] v);
        step(1'b0, 1'b1, 2'd0, v);
    endtask

    task automatic ping(input logic t);
        step(t, 1'b1, 2'd1, 8'h01);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        phase = "R1";
        chk("R1 scale after reset", int'(rdata), 3);
        chk("R1 rst_req after reset", int'(rst_req), 0);

        // R3: default code 3 and every code 1..7
        phase = "R3";
        ticks(lim_of(3) - 1);
        chk("R3 default one tick early", int'(rst_req), 0);
        ticks(1);
        chk("R3 default at limit", int'(rst_req), 1);
        for (int k = 1; k < 8; k++) begin
            do_reset();
            wr_scale(8'(k));
            ticks(lim_of(k) - 1);
            chk("R3 code one tick early", int'(rst_req), 0);
            ticks(1);
            chk("R3 code at limit", int'(rst_req), 1);
        end

        // R9: idle cycles between ticks do not count
        phase = "R9";
        do_reset();
        wr_scale(8'd1);
        for (int i = 0; i < 3; i++) begin
            ticks(1);
            repeat (4) step(1'b0, 1'b0, 2'd0, 8'd0);
        end
        chk("R9 gaps do not advance", int'(rst_req), 0);
        ticks(1);
        chk("R9 fourth tick expires", int'(rst_req), 1);

        // R4: ping restarts, kick register reads zero
        phase = "R4";
        do_reset();
        wr_scale(8'd1);
        ticks(3);
        ping(1'b0);
        addr = 2'd1; #1;
        chk("R4 kick reads zero", int'(rdata), 0);
        addr = 2'd0;
        ticks(3);
        chk("R4 restarted count", int'(rst_req), 0);
        ticks(1);
        chk("R4 expires after full period", int'(rst_req), 1);

        // R4: ping wins over a coincident tick
        phase = "R4 ping+tick";
        do_reset();
        wr_scale(8'd1);
        ticks(3);
        ping(1'b1);
        ticks(3);
        chk("R4 ping priority", int'(rst_req), 0);
        ticks(1);
        chk("R4 ping priority expiry", int'(rst_req), 1);

        // R2, R5, R6: disabled, ping while off, enable from off
        phase = "R2";
        do_reset();
        wr_scale(8'd0);
        ticks(1000);
        chk("R2 no expiry when off", int'(rst_req), 0);
        phase = "R5";
        ping(1'b1);
        ticks(2);
        phase = "R6";
        wr_scale(8'd1);
        ticks(3);
        chk("R5 R6 fresh count after enable", int'(rst_req), 0);
        ticks(1);
        chk("R6 expiry from zero", int'(rst_req), 1);

        // R7: same value keeps counting, different value restarts
        phase = "R7";
        do_reset();
        wr_scale(8'd2);
        ticks(6);
        wr_scale(8'd2);
        ticks(2);
        chk("R7 same value no restart", int'(rst_req), 1);
        do_reset();
        wr_scale(8'd2);
        ticks(6);
        wr_scale(8'd3);
        ticks(15);
        chk("R7 change restarts", int'(rst_req), 0);
        ticks(1);
        chk("R7 change restart expiry", int'(rst_req), 1);

        // R8: sticky request
        phase = "R8";
        ping(1'b1);
        wr_scale(8'd0);
        wr_scale(8'd5);
        ticks(10);
        chk("R8 sticky after writes", int'(rst_req), 1);
        do_reset();
        chk("R8 cleared by reset", int'(rst_req), 0);

        // R10: field masking and unused address
        phase = "R10";
        wr_scale(8'hFD);
        chk("R10 masked scale", int'(rdata), 5);
        step(1'b0, 1'b1, 2'd2, 8'hFF);
        addr = 2'd2; #1;
        chk("R10 unused address reads zero", int'(rdata), 0);
        addr = 2'd0; #1;
        chk("R10 unused write ignored", int'(rdata), 5);
        step(1'b0, 1'b0, 2'd0, 8'd0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule